// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a parallel NOR-style flash device. It watches bus write cycles, each a word address with a 16-bit data value, and follows the unlock handshakes that guard the device's commands. It reports each recognised command as a one-cycle strobe: program (with target address and data), write-buffer load (with sector address) and write-to-buffer abort reset. A separate strobe marks every change of command mode. The block does not touch the memory array; the strobes go to the embedded algorithm engines.

There are two command modes. In normal mode, program and write-buffer load must be preceded by two unlock writes. In unlock bypass mode, those unlock writes are dropped, so a program takes two bus writes instead of four, and only a small set of commands is decoded. Bypass mode is entered and left by command sequences. It is also forced while a high-voltage accelerate level is present. When that level goes away and no embedded program is running, the block returns to normal mode.

All outputs are registered. A strobe is high during the clock cycle that follows the clock edge at which the bus write was sampled. Command codes are matched on the low data byte, data[7:0]. The two unlock addresses are matched on word address bits [10:0] only, against 0x555 and 0x2AA. All other address bits are ignored for the match. Addresses that carry a target or sector are passed through whole.

Top module: `fcmd_decoder`

## Requirements
- R1: A synchronous active-high reset selects normal mode (bypass_mode = 0), clears every strobe and leaves no command sequence in progress.
- R2: In normal mode, the three writes 0xAA at 0x555, 0x55 at 0x2AA and 0x20 at 0x555 switch to bypass mode. A mode-change strobe pulses, and bypass_mode reads 1 from the cycle after the third write.
- R3: In normal mode, the writes 0xAA at 0x555, 0x55 at 0x2AA and 0xA0 at 0x555, followed by a fourth write, produce one program strobe. It carries the fourth write's full address and data.
- R4: In bypass mode, 0xA0 at any address followed by a second write produces one program strobe. It carries the second write's address and data.
- R5: Data 0x25 gives a write-buffer load strobe carrying the full address of that write. In normal mode it must follow the two unlock writes; in bypass mode it is accepted as the first write, at any point between commands.
- R6: In normal mode, a write that does not continue the current unlock sequence returns the decoder to idle. A write of 0xF0 that does not complete the abort reset sequence (R10) also returns the decoder to idle. Neither produces a strobe, and the next command must start again from its first write.
- R7: Only word address bits [10:0] take part in matching 0x555 and 0x2AA; higher address bits never prevent a match.
- R8: In bypass mode, any write outside the accepted commands is ignored: no strobe, and bypass mode is kept. This includes the three-write bypass entry sequence and a lone 0xF0.
- R9: In bypass mode, 0x90 at any address followed by 0x00 at any address returns to normal mode with a mode-change strobe. If the second write is not 0x00, bypass mode is kept.
- R10: The three writes 0xAA at 0x555, 0x55 at 0x2AA and 0xF0 produce an abort-reset strobe in either mode. The mode is unchanged.
- R11: While accel_hv is high, bypass mode is entered (with a mode-change strobe if the block was in normal mode) and held. While accel_hv is high, the R9 exit sequence is ignored.
- R12: After a forced entry, when accel_hv is low and embed_busy is low, the block returns to normal mode with a mode-change strobe. The return waits while embed_busy is high.
- R13: A write is always decoded in the mode the block was in when the write was sampled. If an accelerate-driven mode change happens at the same clock edge, the command strobe and the mode-change strobe pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write valid, one cycle per write |
| wr_addr | input | AW | Word address of the write |
| wr_data | input | DW | Data of the write |
| accel_hv | input | 1 | High-voltage accelerate level present |
| embed_busy | input | 1 | Embedded program operation running |
| prog_stb | output | 1 | Program command strobe |
| prog_addr | output | AW | Program target address |
| prog_data | output | DW | Program data |
| wbuf_stb | output | 1 | Write-buffer load strobe |
| wbuf_addr | output | AW | Write-buffer sector address |
| abort_stb | output | 1 | Write-to-buffer abort reset strobe |
| mode_chg_stb | output | 1 | Command mode changed at this edge |
| bypass_mode | output | 1 | 1 while unlock bypass mode is active |

## Verification
The accelerate level can change at the same clock edge as a command write. The block must then emit both a command strobe and a mode-change strobe in one cycle. The bench provokes this in two ways. It raises accel_hv in the same cycle as the fourth write of a normal-mode program. It also drops accel_hv, with embed_busy low, in the same cycle as the second write of a bypass program. The scoreboard expects the program strobe and then the mode change, both popped in the same monitor cycle, with the program address and data matching the write.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

    localparam int MATCH_W = 11;
    localparam logic [MATCH_W-1:0] ADR_FIRST  = 11'h555;
    localparam logic [MATCH_W-1:0] ADR_SECOND = 11'h2AA;

    localparam logic [7:0] C_KEY1     = 8'hAA;
    localparam logic [7:0] C_KEY2     = 8'h55;
    localparam logic [7:0] C_BYP_IN   = 8'h20;
    localparam logic [7:0] C_PROG     = 8'hA0;
    localparam logic [7:0] C_WBUF     = 8'h25;
    localparam logic [7:0] C_ABORT    = 8'hF0;
    localparam logic [7:0] C_BYP_OUT1 = 8'h90;
    localparam logic [7:0] C_BYP_OUT2 = 8'h00;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_KEY1,
        ST_KEY2,
        ST_PROG,
        ST_BIDLE,
        ST_BPROG,
        ST_BOUT,
        ST_BKEY1,
        ST_BKEY2
    } seq_state_e;

    typedef struct packed {
        logic prog;
        logic wbuf;
        logic abort;
    } cmd_stb_t;

    typedef struct packed {
        logic prog;
        logic wbuf;
        logic abort;
        logic mchg;
    } out_stb_t;

    function automatic logic code_is(input logic [7:0] d, input logic [7:0] c);
        return d == c;
    endfunction

endpackage

// File: rtl/fcmd_addr_match.sv
module fcmd_addr_match
    import fcmd_pkg::*;
#(
    parameter int AW = 23
) (
    input  logic [AW-1:0] addr,
    output logic          hit_a,
    output logic          hit_b
);
    logic [MATCH_W-1:0] low_bits;

    generate
        if (AW >= MATCH_W) begin : g_slice
            assign low_bits = addr[MATCH_W-1:0];
        end else begin : g_pad
            assign low_bits = {{(MATCH_W-AW){1'b0}}, addr};
        end
    endgenerate

    assign hit_a = (low_bits == ADR_FIRST);
    assign hit_b = (low_bits == ADR_SECOND);
endmodule

// File: rtl/fcmd_accel_ctl.sv
module fcmd_accel_ctl (
    input  logic clk,
    input  logic rst,
    input  logic accel_hv,
    input  logic embed_busy,
    input  logic byp_q,
    output logic acc_enter,
    output logic acc_exit,
    output logic acc_lock
);
    logic forced_q;

    assign acc_enter = accel_hv && !byp_q;
    assign acc_exit  = forced_q && byp_q && !accel_hv && !embed_busy;
    assign acc_lock  = accel_hv;

    always_ff @(posedge clk) begin
        if (rst) begin
            forced_q <= 1'b0;
        end else if (accel_hv) begin
            forced_q <= 1'b1;
        end else if (!byp_q || !embed_busy) begin
            forced_q <= 1'b0;
        end
    end
endmodule

// File: rtl/fcmd_seq_fsm.sv
module fcmd_seq_fsm
    import fcmd_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          hit_a,
    input  logic          hit_b,
    input  logic          acc_enter,
    input  logic          acc_exit,
    input  logic          acc_lock,
    output logic          byp_q,
    output logic          byp_d,
    output cmd_stb_t      stb_d
);
    seq_state_e st_q, st_d;
    logic [7:0] code;

    assign code = wr_data[7:0];

    always_comb begin
        st_d  = st_q;
        byp_d = byp_q;
        stb_d = '0;
        if (wr_en) begin
            case (st_q)
                ST_IDLE: begin
                    if (code_is(code, C_KEY1) && hit_a) st_d = ST_KEY1;
                end
                ST_KEY1: begin
                    st_d = (code_is(code, C_KEY2) && hit_b) ? ST_KEY2 : ST_IDLE;
                end
                ST_KEY2: begin
                    st_d = ST_IDLE;
                    if (code_is(code, C_PROG) && hit_a) begin
                        st_d = ST_PROG;
                    end else if (code_is(code, C_BYP_IN) && hit_a) begin
                        byp_d = 1'b1;
                        st_d  = ST_BIDLE;
                    end else if (code_is(code, C_WBUF)) begin
                        stb_d.wbuf = 1'b1;
                    end else if (code_is(code, C_ABORT)) begin
                        stb_d.abort = 1'b1;
                    end
                end
                ST_PROG: begin
                    stb_d.prog = 1'b1;
                    st_d       = ST_IDLE;
                end
                ST_BIDLE: begin
                    if (code_is(code, C_PROG)) begin
                        st_d = ST_BPROG;
                    end else if (code_is(code, C_WBUF)) begin
                        stb_d.wbuf = 1'b1;
                    end else if (code_is(code, C_BYP_OUT1)) begin
                        st_d = ST_BOUT;
                    end else if (code_is(code, C_KEY1) && hit_a) begin
                        st_d = ST_BKEY1;
                    end
                end
                ST_BPROG: begin
                    stb_d.prog = 1'b1;
                    st_d       = ST_BIDLE;
                end
                ST_BOUT: begin
                    st_d = ST_BIDLE;
                    if (code_is(code, C_BYP_OUT2) && !acc_lock) begin
                        byp_d = 1'b0;
                        st_d  = ST_IDLE;
                    end
                end
                ST_BKEY1: begin
                    st_d = (code_is(code, C_KEY2) && hit_b) ? ST_BKEY2 : ST_BIDLE;
                end
                ST_BKEY2: begin
                    st_d = ST_BIDLE;
                    if (code_is(code, C_ABORT)) stb_d.abort = 1'b1;
                end
                default: begin
                    st_d = byp_q ? ST_BIDLE : ST_IDLE;
                end
            endcase
        end
        if (acc_enter) begin
            byp_d = 1'b1;
            st_d  = ST_BIDLE;
        end else if (acc_exit) begin
            byp_d = 1'b0;
            st_d  = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            byp_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            byp_q <= byp_d;
        end
    end
endmodule

// File: rtl/fcmd_decoder.sv
module fcmd_decoder
    import fcmd_pkg::*;
#(
    parameter int AW = 23,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          accel_hv,
    input  logic          embed_busy,
    output logic          prog_stb,
    output logic [AW-1:0] prog_addr,
    output logic [DW-1:0] prog_data,
    output logic          wbuf_stb,
    output logic [AW-1:0] wbuf_addr,
    output logic          abort_stb,
    output logic          mode_chg_stb,
    output logic          bypass_mode
);
    logic     hit_a, hit_b;
    logic     acc_enter, acc_exit, acc_lock;
    logic     byp_q, byp_d;
    cmd_stb_t stb_d;
    out_stb_t out_q;

    fcmd_addr_match #(.AW(AW)) u_match (
        .addr  (wr_addr),
        .hit_a (hit_a),
        .hit_b (hit_b)
    );

    fcmd_accel_ctl u_accel (
        .clk        (clk),
        .rst        (rst),
        .accel_hv   (accel_hv),
        .embed_busy (embed_busy),
        .byp_q      (byp_q),
        .acc_enter  (acc_enter),
        .acc_exit   (acc_exit),
        .acc_lock   (acc_lock)
    );

    fcmd_seq_fsm #(.DW(DW)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .hit_a     (hit_a),
        .hit_b     (hit_b),
        .acc_enter (acc_enter),
        .acc_exit  (acc_exit),
        .acc_lock  (acc_lock),
        .byp_q     (byp_q),
        .byp_d     (byp_d),
        .stb_d     (stb_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q     <= '0;
            prog_addr <= '0;
            prog_data <= '0;
            wbuf_addr <= '0;
        end else begin
            out_q.prog  <= stb_d.prog;
            out_q.wbuf  <= stb_d.wbuf;
            out_q.abort <= stb_d.abort;
            out_q.mchg  <= (byp_d != byp_q);
            if (stb_d.prog) begin
                prog_addr <= wr_addr;
                prog_data <= wr_data;
            end
            if (stb_d.wbuf) wbuf_addr <= wr_addr;
        end
    end

    assign prog_stb     = out_q.prog;
    assign wbuf_stb     = out_q.wbuf;
    assign abort_stb    = out_q.abort;
    assign mode_chg_stb = out_q.mchg;
    assign bypass_mode  = byp_q;
endmodule

// File: rtl/fcmd_decoder_chk.sv
module fcmd_decoder_chk #(
    parameter int AW = 23,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          accel_hv,
    input logic          prog_stb,
    input logic [AW-1:0] prog_addr,
    input logic [DW-1:0] prog_data,
    input logic          wbuf_stb,
    input logic          abort_stb,
    input logic          mode_chg_stb,
    input logic          bypass_mode
);
    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!bypass_mode && !mode_chg_stb && !prog_stb && !wbuf_stb && !abort_stb)); // R1

    AST_MCHG_TRACKS_MODE: assert property (@(posedge clk) disable iff (rst)
        mode_chg_stb == (bypass_mode != $past(bypass_mode))); // R2

    AST_STB_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (prog_stb || wbuf_stb || abort_stb) |-> $past(wr_en)); // R3

    AST_PROG_PAYLOAD: assert property (@(posedge clk) disable iff (rst)
        prog_stb |-> (prog_addr == $past(wr_addr) && prog_data == $past(wr_data))); // R4

    AST_ONE_CMD_STB: assert property (@(posedge clk) disable iff (rst)
        $onehot0({prog_stb, wbuf_stb, abort_stb})); // R10

    AST_ACCEL_FORCES: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(accel_hv)) |-> bypass_mode); // R11

    AST_NO_EXIT_UNDER_HV: assert property (@(posedge clk) disable iff (rst)
        $fell(bypass_mode) |-> !$past(accel_hv)); // R12
endmodule

bind fcmd_decoder fcmd_decoder_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .accel_hv     (accel_hv),
    .prog_stb     (prog_stb),
    .prog_addr    (prog_addr),
    .prog_data    (prog_data),
    .wbuf_stb     (wbuf_stb),
    .abort_stb    (abort_stb),
    .mode_chg_stb (mode_chg_stb),
    .bypass_mode  (bypass_mode)
);

// File: tb/fcmd_decoder_bench.sv
`timescale 1ns/1ps
module fcmd_decoder_bench;
    localparam int AW = 23;
    localparam int DW = 16;
    localparam int K_PROG = 0, K_WBUF = 1, K_ABORT = 2, K_MODE = 3;

    typedef struct {
        int          kind;
        logic [31:0] addr;
        logic [31:0] data;
        string       req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          accel_hv = 1'b0;
    logic          embed_busy = 1'b0;
    logic          prog_stb, wbuf_stb, abort_stb, mode_chg_stb, bypass_mode;
    logic [AW-1:0] prog_addr, wbuf_addr;
    logic [DW-1:0] prog_data;

    exp_t exp_q[$];
    int   n_cmp  = 0;
    int   n_fail = 0;

    always #2 clk = ~clk;

    fcmd_decoder #(.AW(AW), .DW(DW)) u_fcmd_decoder (
        .clk, .rst, .wr_en, .wr_addr, .wr_data, .accel_hv, .embed_busy,
        .prog_stb, .prog_addr, .prog_data, .wbuf_stb, .wbuf_addr,
        .abort_stb, .mode_chg_stb, .bypass_mode
    );

    task automatic expect_ev(input int kind, input logic [31:0] a, input logic [31:0] d, input string req);
        exp_t e;
        e.kind = kind; e.addr = a; e.data = d; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic take(input int kind, input logic [31:0] a, input logic [31:0] d);
        exp_t e;
        n_cmp++;
        if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R6/R8: unexpected strobe kind=%0d addr=%h data=%h, expected none", kind, a, d);
        end else begin
            e = exp_q.pop_front();
            if (e.kind != kind || e.addr != a || e.data != d) begin
                n_fail++;
                $display("FAIL %s: got kind=%0d addr=%h data=%h, expected kind=%0d addr=%h data=%h",
                         e.req, kind, a, d, e.kind, e.addr, e.data);
            end
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (prog_stb)     take(K_PROG, 32'(prog_addr), 32'(prog_data));
            if (wbuf_stb)     take(K_WBUF, 32'(wbuf_addr), 32'd0);
            if (abort_stb)    take(K_ABORT, 32'd0, 32'd0);
            if (mode_chg_stb) take(K_MODE, 32'd0, 32'(bypass_mode));
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle(input string req);
        repeat (2) @(negedge clk);
        n_cmp++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL %s: %0d expected strobes missing, expected 0", exp_q[0].req, exp_q.size());
            exp_q.delete();
        end
    endtask

    task automatic check_mode(input logic e, input string req);
        n_cmp++;
        if (bypass_mode !== e) begin
            n_fail++;
            $display("FAIL %s: bypass_mode=%b expected %b", req, bypass_mode, e);
        end
    endtask

    task automatic unlock2(input logic [AW-1:0] a1, input logic [AW-1:0] a2);
        wr(a1, 16'h00AA);
        wr(a2, 16'h0055);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check_mode(1'b0, "R1");
        n_cmp++;
        if (prog_stb || wbuf_stb || abort_stb || mode_chg_stb) begin
            n_fail++;
            $display("FAIL R1: strobes=%b%b%b%b expected 0000", prog_stb, wbuf_stb, abort_stb, mode_chg_stb);
        end

        // R3: normal four-write program
        unlock2(23'h555, 23'h2AA);
        wr(23'h555, 16'h00A0);
        expect_ev(K_PROG, 32'h12345, 32'hBEEF, "R3");
        wr(23'h12345, 16'hBEEF);
        settle("R3");

        // R7: upper address bits do not block the match
        unlock2(23'h3AD555, 23'h1012AA);
        wr(23'h000D55, 16'h00A0);
        expect_ev(K_PROG, 32'h7FFFFF, 32'h0102, "R7");
        wr(23'h7FFFFF, 16'h0102);
        settle("R7");

        // R6: broken sequence and stray F0 return to idle
        wr(23'h555, 16'h00AA); wr(23'h2AB, 16'h0055);
        wr(23'h555, 16'h00A0); wr(23'h100, 16'h1234);
        wr(23'h455, 16'h00AA); wr(23'h2AA, 16'h0055);
        wr(23'h555, 16'h00A0); wr(23'h200, 16'h0001);
        wr(23'h555, 16'h00AA); wr(23'h2AA, 16'h00F0);
        wr(23'h555, 16'h00A0); wr(23'h300, 16'h0002);
        settle("R6");
        check_mode(1'b0, "R6");

        // R5: normal write-buffer load
        unlock2(23'h555, 23'h2AA);
        expect_ev(K_WBUF, 32'h40000, 32'd0, "R5");
        wr(23'h40000, 16'h0025);
        settle("R5");

        // R10: abort reset in normal mode
        unlock2(23'h555, 23'h2AA);
        expect_ev(K_ABORT, 32'd0, 32'd0, "R10");
        wr(23'h555, 16'h00F0);
        settle("R10");
        check_mode(1'b0, "R10");

        // R2: bypass entry
        unlock2(23'h555, 23'h2AA);
        expect_ev(K_MODE, 32'd0, 32'd1, "R2");
        wr(23'h555, 16'h0020);
        check_mode(1'b1, "R2");
        settle("R2");

        // R4: two-write bypass program
        wr(23'h3ABC, 16'h00A0);
        expect_ev(K_PROG, 32'h7654, 32'h5A5A, "R4");
        wr(23'h7654, 16'h5A5A);
        settle("R4");

        // R5: bypass write-buffer load as first write
        expect_ev(K_WBUF, 32'h80000, 32'd0, "R5");
        wr(23'h80000, 16'h0025);
        settle("R5");

        // R8: other commands ignored in bypass
        wr(23'h555, 16'h0080); wr(23'h2AA, 16'h0030);
        unlock2(23'h555, 23'h2AA); wr(23'h555, 16'h0020);
        wr(23'h555, 16'h00F0);
        settle("R8");
        check_mode(1'b1, "R8");
        wr(23'h0, 16'h00A0);
        expect_ev(K_PROG, 32'h111, 32'h2222, "R8");
        wr(23'h111, 16'h2222);
        settle("R8");

        // R10: abort reset in bypass mode
        unlock2(23'h555, 23'h2AA);
        expect_ev(K_ABORT, 32'd0, 32'd0, "R10");
        wr(23'h555, 16'h00F0);
        settle("R10");
        check_mode(1'b1, "R10");

        // R9: bypass exit
        wr(23'h20000, 16'h0090); wr(23'h0, 16'h0001);
        settle("R9");
        check_mode(1'b1, "R9");
        wr(23'h20000, 16'h0090);
        expect_ev(K_MODE, 32'd0, 32'd0, "R9");
        wr(23'h333, 16'h0000);
        check_mode(1'b0, "R9");
        settle("R9");

        // R11: accelerate level forces bypass, blocks command exit
        expect_ev(K_MODE, 32'd0, 32'd1, "R11");
        accel_hv = 1'b1;
        @(negedge clk);
        check_mode(1'b1, "R11");
        wr(23'h20000, 16'h0090); wr(23'h0, 16'h0000);
        settle("R11");
        check_mode(1'b1, "R11");

        // R12: release waits for embedded program
        embed_busy = 1'b1;
        accel_hv = 1'b0;
        repeat (3) @(negedge clk);
        check_mode(1'b1, "R12");
        expect_ev(K_MODE, 32'd0, 32'd0, "R12");
        embed_busy = 1'b0;
        @(negedge clk);
        check_mode(1'b0, "R12");
        settle("R12");

        // R13: program write and accelerate entry at the same edge
        unlock2(23'h555, 23'h2AA);
        wr(23'h555, 16'h00A0);
        expect_ev(K_PROG, 32'h4321, 32'hCAFE, "R13");
        expect_ev(K_MODE, 32'd0, 32'd1, "R13");
        accel_hv = 1'b1;
        wr(23'h4321, 16'hCAFE);
        check_mode(1'b1, "R13");
        settle("R13");

        // R13: bypass program write and accelerate release at the same edge
        wr(23'h0, 16'h00A0);
        expect_ev(K_PROG, 32'h6000, 32'h0F0F, "R13");
        expect_ev(K_MODE, 32'd0, 32'd0, "R13");
        accel_hv = 1'b0;
        wr(23'h6000, 16'h0F0F);
        check_mode(1'b0, "R13");
        settle("R13");

        finish_run();
    end
endmodule